// File: doc/BRIEF.md
# Multi-Channel Compare Unit with One-Shot Arming

This block holds a bank of compare channels that all watch one shared free-running timer value. Each channel has a compare value and a configuration word. The configuration word turns the channel on or off, and it also selects whether the channel fires on every match or only once. When the timer equals the compare value of a channel that is switched on, the channel produces a one-clock event pulse.

A channel in one-shot mode also needs its bit in a shared arming word. When the channel fires, the hardware clears that bit, so the channel stays silent until software arms it again. Software can only replace the arming word as a whole. A write in the same cycle as a hardware clear therefore decides the final value, and the write wins.

Software reaches all registers through a simple write port and a combinational read port. Compare values sit at addresses 0 to NCH-1. Configuration words sit at addresses NCH to 2·NCH-1. The arming word sits at address 2·NCH.

Top module: `cmpu_top`

## Requirements
- R1: After reset every compare value, configuration word and the arming word read as 0, and all event outputs are low.
- R2: A channel whose configuration bit 0 is 1 pulses its event output high for exactly the one cycle after the clock edge at which the timer input equals its compare value.
- R3: A channel whose configuration bit 0 is 0 never produces an event, whatever its compare value or arming bit.
- R4: When a channel with configuration bit 1 set fires, its bit in the arming word reads 0 from the cycle of the pulse onward, unless software writes the arming word at that same edge.
- R5: A channel with configuration bit 1 set and its arming bit at 0 produces no event on a match.
- R6: A channel with configuration bit 1 clear fires on every match and ignores its arming bit.
- R7: A write to the arming address replaces all NCH bits with wr_data[NCH-1:0]. If the write happens at the same edge as a hardware clear, the written value is kept.
- R8: Hardware never changes compare values or configuration words. Each reads back exactly as written: TW bits for a compare value, and bits [1:0] for a configuration word (0 = on, 1 = one-shot), with the upper bits of a configuration word reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_i | input | TW | Shared free-running timer value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Read data (combinational) |
| ev_o | output | NCH | Per-channel one-cycle event pulses |

## Verification
The hardest case to reach is a word write to the arming register at the very edge where a one-shot channel matches. Random stimulus almost never lines these two up. A directed sequence therefore arms a one-shot channel, then drives the matching timer value and the arming write in the same cycle. It checks that the pulse appears and that the bit survives. Random cycles then aim the timer at a channel's current compare value half the time, so that matches, re-arming writes and configuration changes often fall together.

// File: rtl/cmpu_pkg.sv
// Shared constants for the compare unit.
// Assumes: configuration words carry the on bit at 0 and the one-shot bit at 1.
package cmpu_pkg;
    localparam int CFG_ON_BIT     = 0;
    localparam int CFG_SINGLE_BIT = 1;
endpackage

// File: rtl/cmpu_regs.sv
// Compare-value and configuration storage, written only by the register port.
// Assumes: TW <= DW; addresses 0..NCH-1 hold compare values and NCH..2NCH-1 hold configuration.
module cmpu_regs #(
    parameter int NCH = 8,
    parameter int TW  = 16,
    parameter int DW  = 16,
    parameter int AW  = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [DW-1:0]           wr_data,
    output logic [NCH-1:0][TW-1:0]  cmp_q,
    output logic [NCH-1:0]          cfg_on,
    output logic [NCH-1:0]          cfg_single
);
    import cmpu_pkg::*;

    // Store compare values and mode bits on matching writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q      <= '0;
            cfg_on     <= '0;
            cfg_single <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == AW'(i))
                    cmp_q[i] <= wr_data[TW-1:0];
                if (wr_addr == AW'(NCH + i)) begin
                    cfg_on[i]     <= wr_data[CFG_ON_BIT];
                    cfg_single[i] <= wr_data[CFG_SINGLE_BIT];
                end
            end
        end
    end
endmodule

// File: rtl/cmpu_arm.sv
// Arming word for one-shot channels: whole-word writes, per-bit hardware clear.
// Assumes: a software write at the same edge as a clear takes priority.
module cmpu_arm #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           word_wr,
    input  logic [NCH-1:0] word_data,
    input  logic [NCH-1:0] hw_clr,
    output logic [NCH-1:0] armed_q
);
    // Replace the whole word on a write, otherwise drop the bits that fired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= '0;
        else if (word_wr)
            armed_q <= word_data;
        else
            armed_q <= armed_q & ~hw_clr;
    end
endmodule

// File: rtl/cmpu_chan.sv
// One compare channel: equality match, mode gating and a registered pulse.
// Assumes: the timer and the settings are stable across the sampling edge.
module cmpu_chan #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer_i,
    input  logic [TW-1:0] cmp_i,
    input  logic          on_i,
    input  logic          single_i,
    input  logic          armed_i,
    output logic          clr_o,
    output logic          ev_o
);
    logic hit;

    // A match counts if the channel is on and, in one-shot mode, armed.
    always_comb begin
        hit   = on_i && (timer_i == cmp_i) && (!single_i || armed_i);
        clr_o = hit && single_i;
    end

    // Register the hit as a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ev_o <= 1'b0;
        else
            ev_o <= hit;
    end
endmodule

// File: rtl/cmpu_top.sv
// Compare unit top: register bank, arming word, per-channel matchers and read mux.
// Assumes: NCH <= DW and TW <= DW; the read port is combinational.
module cmpu_top #(
    parameter int NCH = 8,
    parameter int TW  = 16,
    parameter int DW  = 16,
    parameter int AW  = $clog2(2 * NCH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   timer_i,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic [NCH-1:0]  ev_o
);
    import cmpu_pkg::*;

    localparam int ARM_ADDR = 2 * NCH;

    logic [NCH-1:0][TW-1:0] cmp_q;
    logic [NCH-1:0]         cfg_on;
    logic [NCH-1:0]         cfg_single;
    logic [NCH-1:0]         see_q;
    logic [NCH-1:0]         hw_clr;
    logic                   see_wr;

    // Decode a write to the arming word.
    always_comb see_wr = wr_en && (wr_addr == AW'(ARM_ADDR));

    cmpu_regs #(.NCH(NCH), .TW(TW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_q(cmp_q), .cfg_on(cfg_on), .cfg_single(cfg_single)
    );

    cmpu_arm #(.NCH(NCH)) u_arm (
        .clk(clk), .rst_n(rst_n), .word_wr(see_wr), .word_data(wr_data[NCH-1:0]),
        .hw_clr(hw_clr), .armed_q(see_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        cmpu_chan #(.TW(TW)) u_chan (
            .clk(clk), .rst_n(rst_n), .timer_i(timer_i), .cmp_i(cmp_q[g]),
            .on_i(cfg_on[g]), .single_i(cfg_single[g]), .armed_i(see_q[g]),
            .clr_o(hw_clr[g]), .ev_o(ev_o[g])
        );
    end

    // Select the register named by rd_addr.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == AW'(i))
                rd_data = DW'(cmp_q[i]);
            if (rd_addr == AW'(NCH + i)) begin
                rd_data[CFG_ON_BIT]     = cfg_on[i];
                rd_data[CFG_SINGLE_BIT] = cfg_single[i];
            end
        end
        if (rd_addr == AW'(ARM_ADDR))
            rd_data = DW'(see_q);
    end
endmodule

// File: rtl/cmpu_top_chk.sv
// Property checker for the compare unit, bound to every cmpu_top instance.
// Assumes: it observes the top's internal register state through the bind.
module cmpu_top_chk #(
    parameter int NCH = 8,
    parameter int TW  = 16,
    parameter int DW  = 16,
    parameter int AW  = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [TW-1:0]          timer_i,
    input logic                   wr_en,
    input logic [AW-1:0]          wr_addr,
    input logic [DW-1:0]          wr_data,
    input logic [NCH-1:0]         ev_o,
    input logic [NCH-1:0][TW-1:0] cmp_q,
    input logic [NCH-1:0]         cfg_on,
    input logic [NCH-1:0]         cfg_single,
    input logic [NCH-1:0]         see_q
);
    logic see_wr;
    // Recompute the arming-word write strobe from the port.
    always_comb see_wr = wr_en && (wr_addr == AW'(2 * NCH));

    for (genvar g = 0; g < NCH; g++) begin : g_prop
        // R3
        off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_o[g] |-> $past(cfg_on[g]));
        // R2
        match_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev_o[g] |-> ($past(timer_i) == $past(cmp_q[g])));
        // R5
        disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_o[g] && $past(cfg_single[g])) |-> $past(see_q[g]));
        // R4
        auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ev_o[g] && $past(cfg_single[g]) && !$past(see_wr)) |-> !see_q[g]);
    end

    // R7
    word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        see_wr |=> (see_q == $past(wr_data[NCH-1:0])));
endmodule

bind cmpu_top cmpu_top_chk #(.NCH(NCH), .TW(TW), .DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .timer_i(timer_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ev_o(ev_o), .cmp_q(cmp_q), .cfg_on(cfg_on),
    .cfg_single(cfg_single), .see_q(see_q)
);

// File: tb/cmpu_top_tb.sv
// Self-checking bench: directed corner cases, then seeded random cycles against a model.
module cmpu_top_tb;
    localparam int NCH = 8;
    localparam int TW  = 16;
    localparam int DW  = 16;
    localparam int AW  = $clog2(2 * NCH + 1);
    localparam int ARM = 2 * NCH;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [TW-1:0]   timer_i = '0;
    logic            wr_en = 1'b0;
    logic [AW-1:0]   wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [NCH-1:0]  ev_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [TW-1:0]  m_cmp [NCH];
    logic [NCH-1:0] m_on, m_single, m_arm;

    cmpu_top #(.NCH(NCH), .TW(TW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .timer_i(timer_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ev_o(ev_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] model_fire(input logic [TW-1:0] t);
        logic [NCH-1:0] f;
        for (int i = 0; i < NCH; i++)
            f[i] = m_on[i] && (t == m_cmp[i]) && (!m_single[i] || m_arm[i]);
        return f;
    endfunction

    function automatic logic [DW-1:0] model_read(input int a);
        if (a < NCH) return DW'(m_cmp[a]);
        if (a < 2 * NCH) return DW'({m_single[a - NCH], m_on[a - NCH]});
        if (a == ARM) return DW'(m_arm);
        return '0;
    endfunction

    // One clock: drive at the falling edge, check the event vector after the rising edge.
    task automatic step(input logic [TW-1:0] t, input bit we, input int a,
                        input logic [DW-1:0] d, input string tag);
        logic [NCH-1:0] exp;
        @(negedge clk);
        timer_i = t; wr_en = we; wr_addr = AW'(a); wr_data = d;
        exp = model_fire(t);
        @(posedge clk);
        #1;
        m_arm = m_arm & ~(exp & m_single);
        if (we) begin
            if (a < NCH) m_cmp[a] = d[TW-1:0];
            else if (a < 2 * NCH) begin
                m_on[a - NCH] = d[0];
                m_single[a - NCH] = d[1];
            end else if (a == ARM) m_arm = d[NCH-1:0];
        end
        wr_en = 1'b0;
        check(ev_o == exp, tag, DW'(ev_o), DW'(exp));
    endtask

    task automatic rd_chk(input int a, input string tag);
        rd_addr = AW'(a);
        #1;
        check(rd_data == model_read(a), tag, rd_data, model_read(a));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) m_cmp[i] = '0;
        m_on = '0; m_single = '0; m_arm = '0;
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset state of outputs and every register
        check(ev_o == '0, "R1 events", DW'(ev_o), '0);
        for (int a = 0; a <= ARM; a++) rd_chk(a, "R1 register");

        // R8: writes read back unchanged, upper config bits dropped
        step(0, 1, 0, 16'd5, "R8 write");
        step(0, 1, NCH + 0, 16'hFFF1, "R8 write");
        rd_chk(0, "R8 compare readback");
        rd_chk(NCH + 0, "R8 config readback");

        // R2: pulse after a match, one cycle wide
        step(5, 0, 0, 0, "R2 match");
        check(ev_o[0] == 1'b1, "R2 pulse", DW'(ev_o), 16'h1);
        step(6, 0, 0, 0, "R2 one wide");

        // R3: disabled channel stays quiet
        step(0, 1, 1, 16'd7, "R3 setup");
        step(7, 0, 0, 0, "R3 off");
        check(ev_o[1] == 1'b0, "R3 no pulse", DW'(ev_o), 16'h0);

        // R4 / R5: one-shot fires once and clears its arm bit
        step(0, 1, 2, 16'd9, "R4 setup");
        step(0, 1, NCH + 2, 16'd3, "R4 setup");
        step(0, 1, ARM, 16'h0004, "R4 arm");
        step(9, 0, 0, 0, "R4 fire");
        check(ev_o[2] == 1'b1, "R4 pulse", DW'(ev_o), 16'h4);
        rd_chk(ARM, "R4 arm cleared");
        rd_chk(NCH + 2, "R8 mode kept after fire");
        step(9, 0, 0, 0, "R5 disarmed");
        check(ev_o == '0, "R5 silent", DW'(ev_o), 16'h0);

        // R6: repeating channel ignores its zero arm bit
        step(5, 0, 0, 0, "R6 repeat");
        check(ev_o[0] == 1'b1, "R6 pulse", DW'(ev_o), 16'h1);

        // R7: write at the same edge as the hardware clear wins
        step(0, 1, ARM, 16'h0004, "R7 arm");
        step(9, 1, ARM, 16'h0004, "R7 race");
        check(ev_o[2] == 1'b1, "R7 pulse", DW'(ev_o), 16'h4);
        rd_chk(ARM, "R7 write kept");
        step(9, 0, 0, 0, "R7 refire");
        rd_chk(ARM, "R7 cleared after refire");

        // R3: switching a channel off stops it
        step(0, 1, NCH + 0, 16'h0, "R3 disable");
        step(5, 0, 0, 0, "R3 disabled match");

        // Random phase covering R2..R8 together
        for (int c = 0; c < 4000; c++) begin
            int k;
            logic [TW-1:0] t;
            bit we;
            int a;
            k = int'($urandom % NCH);
            t = ($urandom % 2) ? m_cmp[k] : TW'($urandom % 32);
            we = ($urandom % 4) == 0;
            a = int'($urandom % (ARM + 1));
            step(t, we, a, DW'(($urandom % 2) ? $urandom % 32 : $urandom), "R2 R3 R5 R6 random");
            rd_chk(ARM, "R4 R7 random arm word");
            rd_chk(int'($urandom % (ARM + 1)), "R8 random readback");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule